// File: doc/BRIEF.md
# Stuck-at Fault Grading Engine

This block grades a fixed set of eight test vectors against every single stuck-at fault of a small three-input combinational function, Z = (~A & B) | (B & C). It holds two copies of that function. One is fault-free. The other has a forcing point at each fault site, and exactly one fault is injected into it at a time. The vector set and its order come in on one input bus. A start pulse then sweeps every (fault, vector) pair, one pair per clock, with the fault index as the outer loop and the vector position as the inner loop.

A fault is never dropped once it has been detected. Every fault therefore meets every vector, and the stored results form a complete fault dictionary. For each fault the dictionary holds the per-position fail pattern and the faulty response. The fault-free response is stored once. From the dictionary the engine derives four figures: how many vectors catch each fault, how many faults each vector position catches, the running count of distinct faults caught up to each position, and a matrix that marks pairs of faults the vector set cannot tell apart. A test engineer uses these figures to rank and trim a vector set and to build a diagnosis table.

Top module: `stuck_fault_grader`

## Requirements
- R1: A vector is read as {C,B,A}, with C in bit 2. The vector at position p is vec_order[3p+2:3p], and good_resp bit (7-p) holds (~A & B) | (B & C) for that vector. Position 0 is the first vector applied.
- R2: rd_fault values 0..7 select faults F1..F8: F1 inverter output stuck at 1, F2 B input of the inverter-fed AND stuck at 1, F3 B input of the B-and-C AND stuck at 1, F4 inverter-fed input of the first AND stuck at 1, F5 first AND output stuck at 0, F6 second AND output stuck at 0, F7 output Z stuck at 1, F8 output Z stuck at 0. rd_bad bit (7-p) is the faulty output for position p.
- R3: rd_fail bit (7-p) is 1 exactly when the fault-free and faulty outputs differ for position p. For the order 3,4,2,7,0,1,5,6 the good response is 00110001, F1 gives 10000000, F7 gives 11001110 and F8 gives 00110001.
- R4: Faults are not dropped. rd_hits is the number of positions that detect the selected fault, counting every detection (F7 gives 5 under the order in R3).
- R5: A start seen while idle raises busy on the next cycle. Busy stays high for 64 cycles, one per pair. On the 64th edge after acceptance busy falls and done rises. Done then stays high until the next accepted start.
- R6: An accepted start clears done and every stored pattern, response and derived count before the first pair is evaluated.
- R7: A start while busy has no effect, and vec_order is sampled only at an accepted start. Changing vec_order during a run does not alter that run's results.
- R8: vec_hits[4p+3:4p] is the number of faults that the vector at position p detects.
- R9: cum_cov[4p+3:4p] is the number of distinct faults detected by positions 0..p; coverage is this value over 8. Under the order in R3 it reaches 8 at position 3.
- R10: equiv bit 8i+j is 1 exactly when done is high, i differs from j, and faults i and j have identical fail patterns. Under the order in R3 only F1 and F4 pair up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a grading sweep when idle |
| vec_order | input | 24 | Eight 3-bit vectors; position p at bits 3p+2:3p |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished; results valid |
| rd_fault | input | 3 | Fault selector for readback (0 = F1) |
| rd_fail | output | 8 | Fail pattern of the selected fault, position 0 in bit 7 |
| rd_bad | output | 8 | Faulty response of the selected fault, position 0 in bit 7 |
| rd_hits | output | 4 | Number of vectors detecting the selected fault |
| good_resp | output | 8 | Fault-free response, position 0 in bit 7 |
| vec_hits | output | 32 | Per-position detection counts, 4 bits each |
| cum_cov | output | 32 | Per-position cumulative distinct-fault counts, 4 bits each |
| equiv | output | 64 | Indistinguishable-fault matrix, bit 8i+j |

## Verification
The bench goes after the ordering corner. A design that put the first vector in the wrong bit would produce mirrored patterns, and the reference order catches this because its expected strings are not palindromes. It repeats one vector at every position. A design that dropped detected faults, or that stopped counting after the first hit, would then report one hit instead of eight, and it would leave the equivalence classes wrong. It also pulses start and scrambles vec_order mid-run. A design that restarted, or that read the order live, would return results for the wrong vectors or finish late. Finally it checks that a fresh start wipes the previous run's dictionary before any new pair lands. A missing clear would leave stale fail bits visible.

// File: rtl/sfg_pkg.sv
`timescale 1ns/1ps
package sfg_pkg;

  localparam int VEC_BITS = 3;
  localparam int NUM_VEC  = 8;
  localparam int NUM_FLT  = 8;
  localparam int MAX_W    = (NUM_VEC > NUM_FLT) ? NUM_VEC : NUM_FLT;
  localparam int CNT_W    = $clog2(MAX_W + 1);

  // Forcing points inside the faulty copy
  typedef enum logic [2:0] {
    S_INV_OUT  = 3'd0,
    S_AND1_INV = 3'd1,
    S_AND1_B   = 3'd2,
    S_AND1_OUT = 3'd3,
    S_AND2_B   = 3'd4,
    S_AND2_OUT = 3'd5,
    S_OUT      = 3'd6
  } site_e;

  typedef struct packed {
    site_e site;
    logic  stuck;
  } fault_t;

  // Collapsed fault list, index 0 is F1
  function automatic fault_t fault_of(input logic [2:0] idx);
    fault_t f;
    case (idx)
      3'd0:    f = '{site: S_INV_OUT,  stuck: 1'b1};
      3'd1:    f = '{site: S_AND1_B,   stuck: 1'b1};
      3'd2:    f = '{site: S_AND2_B,   stuck: 1'b1};
      3'd3:    f = '{site: S_AND1_INV, stuck: 1'b1};
      3'd4:    f = '{site: S_AND1_OUT, stuck: 1'b0};
      3'd5:    f = '{site: S_AND2_OUT, stuck: 1'b0};
      3'd6:    f = '{site: S_OUT,      stuck: 1'b1};
      default: f = '{site: S_OUT,      stuck: 1'b0};
    endcase
    return f;
  endfunction

  // Netlist with a forcing mux at every site; v = {C,B,A}
  function automatic logic eval_net(input logic [2:0] v, input logic inj, input fault_t f);
    logic a, b, c, inv, g1a, g1b, g1, g2b, g2, z;
    a   = v[0];
    b   = v[1];
    c   = v[2];
    inv = ~a;
    if (inj && f.site == S_INV_OUT)  inv = f.stuck;
    g1a = inv;
    if (inj && f.site == S_AND1_INV) g1a = f.stuck;
    g1b = b;
    if (inj && f.site == S_AND1_B)   g1b = f.stuck;
    g1  = g1a & g1b;
    if (inj && f.site == S_AND1_OUT) g1  = f.stuck;
    g2b = b;
    if (inj && f.site == S_AND2_B)   g2b = f.stuck;
    g2  = g2b & c;
    if (inj && f.site == S_AND2_OUT) g2  = f.stuck;
    z   = g1 | g2;
    if (inj && f.site == S_OUT)      z   = f.stuck;
    return z;
  endfunction

  function automatic logic [CNT_W-1:0] count_ones(input logic [MAX_W-1:0] x);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < MAX_W; i++) n = n + CNT_W'(x[i]);
    return n;
  endfunction

endpackage

// File: rtl/sfg_sequencer.sv
`timescale 1ns/1ps
module sfg_sequencer import sfg_pkg::*; #(
  parameter int VEC_N = NUM_VEC,
  parameter int FLT_N = NUM_FLT,
  parameter int VB    = VEC_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [VEC_N*VB-1:0]      order_in,
  output logic                     busy,
  output logic                     done,
  output logic                     clear,
  output logic [$clog2(FLT_N)-1:0] flt_idx,
  output logic [$clog2(VEC_N)-1:0] pos_idx,
  output logic [VB-1:0]            cur_vec
);

  localparam int PAIR_N = VEC_N * FLT_N;
  localparam int PC_W   = $clog2(PAIR_N);
  localparam int PI_W   = $clog2(VEC_N);

  logic [PC_W-1:0]       pair_q;
  logic [VEC_N*VB-1:0]   order_q;
  logic                  last_pair;

  assign clear     = start && !busy;
  assign last_pair = (pair_q == PC_W'(PAIR_N - 1));
  assign flt_idx   = pair_q[PC_W-1:PI_W];
  assign pos_idx   = pair_q[PI_W-1:0];
  assign cur_vec   = order_q[pos_idx*VB +: VB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      pair_q  <= '0;
      order_q <= '0;
    end else if (clear) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      pair_q  <= '0;
      order_q <= order_in;
    end else if (busy) begin
      if (last_pair) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        pair_q <= '0;
      end else begin
        pair_q <= pair_q + PC_W'(1);
      end
    end
  end

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && pair_q == '0));

  p_run_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_pair) |=> (busy && !done));

  p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_pair) |=> (done && !busy));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_pair) |=> (pair_q == $past(pair_q) + PC_W'(1) && $stable(order_q)));

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

// File: rtl/sfg_fault_pair.sv
`timescale 1ns/1ps
module sfg_fault_pair import sfg_pkg::*; #(
  parameter int FLT_N = NUM_FLT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               vec,
  input  logic                     inj_en,
  input  logic [$clog2(FLT_N)-1:0] flt_idx,
  output logic                     good_z,
  output logic                     bad_z,
  output logic                     mismatch
);

  logic   n_inv, n_and1, n_and2;
  fault_t sel;

  // Fault-free copy as plain gates
  always_comb begin
    n_inv  = ~vec[0];
    n_and1 = n_inv & vec[1];
    n_and2 = vec[1] & vec[2];
    good_z = n_and1 | n_and2;
  end

  // Faulty copy with forcing points
  assign sel      = fault_of(3'(flt_idx));
  assign bad_z    = eval_net(vec, inj_en, sel);
  assign mismatch = good_z ^ bad_z;

  p_no_inj_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |-> !mismatch);

  p_out_sa1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && flt_idx == 3'd6) |-> bad_z);

  p_out_sa0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && flt_idx == 3'd7) |-> !bad_z);

endmodule

// File: rtl/sfg_dictionary.sv
`timescale 1ns/1ps
module sfg_dictionary import sfg_pkg::*; #(
  parameter int VEC_N = NUM_VEC,
  parameter int FLT_N = NUM_FLT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     wr,
  input  logic                     done,
  input  logic [$clog2(FLT_N)-1:0] flt_idx,
  input  logic [$clog2(VEC_N)-1:0] pos_idx,
  input  logic                     good_z,
  input  logic                     bad_z,
  input  logic                     miss,
  input  logic [$clog2(FLT_N)-1:0] rd_idx,
  output logic [VEC_N-1:0]         rd_fail,
  output logic [VEC_N-1:0]         rd_bad,
  output logic [VEC_N-1:0]         good_resp,
  output logic [FLT_N*VEC_N-1:0]   fail_flat
);

  localparam int PI_W = $clog2(VEC_N);

  logic [VEC_N-1:0] fail_q [FLT_N];
  logic [VEC_N-1:0] bad_q  [FLT_N];
  logic [VEC_N-1:0] good_q;
  logic [PI_W-1:0]  col;

  // First applied vector lands in the most significant bit
  assign col = PI_W'(VEC_N - 1) - pos_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      for (int f = 0; f < FLT_N; f++) begin
        fail_q[f] <= '0;
        bad_q[f]  <= '0;
      end
    end else if (clear) begin
      good_q <= '0;
      for (int f = 0; f < FLT_N; f++) begin
        fail_q[f] <= '0;
        bad_q[f]  <= '0;
      end
    end else if (wr) begin
      fail_q[flt_idx][col] <= miss;
      bad_q[flt_idx][col]  <= bad_z;
      good_q[col]          <= good_z;
    end
  end

  assign rd_fail   = fail_q[rd_idx];
  assign rd_bad    = bad_q[rd_idx];
  assign good_resp = good_q;

  for (genvar g = 0; g < FLT_N; g++) begin : g_flat
    assign fail_flat[g*VEC_N +: VEC_N] = fail_q[g];

    p_sig_consistent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fail_q[g] == (good_q ^ bad_q[g])));
  end

endmodule

// File: rtl/sfg_grader.sv
`timescale 1ns/1ps
module sfg_grader import sfg_pkg::*; #(
  parameter int VEC_N = NUM_VEC,
  parameter int FLT_N = NUM_FLT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     done,
  input  logic [FLT_N*VEC_N-1:0]   fail_flat,
  input  logic [$clog2(FLT_N)-1:0] rd_idx,
  output logic [CNT_W-1:0]         rd_hits,
  output logic [VEC_N*CNT_W-1:0]   vec_hits,
  output logic [VEC_N*CNT_W-1:0]   cum_cov,
  output logic [FLT_N*FLT_N-1:0]   equiv
);

  logic [VEC_N-1:0] row     [FLT_N];
  logic [FLT_N-1:0] det     [VEC_N];
  logic [FLT_N-1:0] seen_at [VEC_N];

  for (genvar f = 0; f < FLT_N; f++) begin : g_row
    assign row[f] = fail_flat[f*VEC_N +: VEC_N];
  end

  assign rd_hits = count_ones(MAX_W'(row[rd_idx]));

  for (genvar p = 0; p < VEC_N; p++) begin : g_pos
    for (genvar f = 0; f < FLT_N; f++) begin : g_det
      assign det[p][f] = row[f][VEC_N-1-p];
    end
    if (p == 0) begin : g_first
      assign seen_at[p] = det[p];
    end else begin : g_next
      assign seen_at[p] = seen_at[p-1] | det[p];
    end
    assign vec_hits[p*CNT_W +: CNT_W] = count_ones(MAX_W'(det[p]));
    assign cum_cov[p*CNT_W +: CNT_W]  = count_ones(MAX_W'(seen_at[p]));

    p_hits_within_cov_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_hits[p*CNT_W +: CNT_W] <= cum_cov[p*CNT_W +: CNT_W]);

    if (p > 0) begin : g_mono
      p_cov_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cum_cov[p*CNT_W +: CNT_W] >= cum_cov[(p-1)*CNT_W +: CNT_W]);
    end
  end

  for (genvar i = 0; i < FLT_N; i++) begin : g_eq_i
    for (genvar j = 0; j < FLT_N; j++) begin : g_eq_j
      if (i == j) begin : g_diag
        assign equiv[i*FLT_N + j] = 1'b0;
      end else begin : g_off
        assign equiv[i*FLT_N + j] = done && (row[i] == row[j]);

        p_equiv_weight_r10: assert property (@(posedge clk) disable iff (!rst_n)
          equiv[i*FLT_N + j] |-> (count_ones(MAX_W'(row[i])) == count_ones(MAX_W'(row[j]))));
      end
    end
  end

endmodule

// File: rtl/stuck_fault_grader.sv
`timescale 1ns/1ps
module stuck_fault_grader import sfg_pkg::*; #(
  parameter int VEC_N = NUM_VEC,
  parameter int FLT_N = NUM_FLT,
  parameter int VB    = VEC_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [VEC_N*VB-1:0]      vec_order,
  output logic                     busy,
  output logic                     done,
  input  logic [$clog2(FLT_N)-1:0] rd_fault,
  output logic [VEC_N-1:0]         rd_fail,
  output logic [VEC_N-1:0]         rd_bad,
  output logic [CNT_W-1:0]         rd_hits,
  output logic [VEC_N-1:0]         good_resp,
  output logic [VEC_N*CNT_W-1:0]   vec_hits,
  output logic [VEC_N*CNT_W-1:0]   cum_cov,
  output logic [FLT_N*FLT_N-1:0]   equiv
);

  localparam int FI_W = $clog2(FLT_N);
  localparam int PI_W = $clog2(VEC_N);

  logic                   clear;
  logic [FI_W-1:0]        flt_idx;
  logic [PI_W-1:0]        pos_idx;
  logic [VB-1:0]          cur_vec;
  logic                   good_z, bad_z, mismatch;
  logic [FLT_N*VEC_N-1:0] fail_flat;

  sfg_sequencer #(.VEC_N(VEC_N), .FLT_N(FLT_N), .VB(VB)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .order_in(vec_order),
    .busy(busy), .done(done), .clear(clear),
    .flt_idx(flt_idx), .pos_idx(pos_idx), .cur_vec(cur_vec)
  );

  sfg_fault_pair #(.FLT_N(FLT_N)) u_pair (
    .clk(clk), .rst_n(rst_n), .vec(3'(cur_vec)), .inj_en(busy),
    .flt_idx(flt_idx), .good_z(good_z), .bad_z(bad_z), .mismatch(mismatch)
  );

  sfg_dictionary #(.VEC_N(VEC_N), .FLT_N(FLT_N)) u_dict (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr(busy), .done(done),
    .flt_idx(flt_idx), .pos_idx(pos_idx),
    .good_z(good_z), .bad_z(bad_z), .miss(mismatch),
    .rd_idx(rd_fault), .rd_fail(rd_fail), .rd_bad(rd_bad),
    .good_resp(good_resp), .fail_flat(fail_flat)
  );

  sfg_grader #(.VEC_N(VEC_N), .FLT_N(FLT_N)) u_grade (
    .clk(clk), .rst_n(rst_n), .done(done), .fail_flat(fail_flat),
    .rd_idx(rd_fault), .rd_hits(rd_hits), .vec_hits(vec_hits),
    .cum_cov(cum_cov), .equiv(equiv)
  );

endmodule

// File: tb/stuck_fault_grader_test.sv
`timescale 1ns/1ps
module stuck_fault_grader_test;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [23:0] vec_order;
  logic        busy, done;
  logic [2:0]  rd_fault;
  logic [7:0]  rd_fail, rd_bad, good_resp;
  logic [3:0]  rd_hits;
  logic [31:0] vec_hits, cum_cov;
  logic [63:0] equiv;

  always #2.5 clk = ~clk;

  stuck_fault_grader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_order(vec_order),
    .busy(busy), .done(done), .rd_fault(rd_fault), .rd_fail(rd_fail),
    .rd_bad(rd_bad), .rd_hits(rd_hits), .good_resp(good_resp),
    .vec_hits(vec_hits), .cum_cov(cum_cov), .equiv(equiv)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Truth tables over vector value v (bit v set = output 1)
  bit [7:0] good_tab = 8'hC4;
  bit [7:0] bad_tab [8] = '{8'hCC, 8'hD5, 8'hF4, 8'hCC, 8'hC0, 8'h44, 8'hFF, 8'h00};

  int       ord [8];
  bit [7:0] e_good;
  bit [7:0] e_fail [8];
  bit [7:0] e_bad  [8];
  int       e_hits [8];
  int       e_vhit [8];
  int       e_cum  [8];
  bit [63:0] e_eq;

  function automatic logic [23:0] pack_order();
    logic [23:0] r;
    for (int p = 0; p < 8; p++) r[3*p +: 3] = 3'(ord[p]);
    return r;
  endfunction

  task automatic build_expect();
    int seen[$];
    e_good = '0;
    for (int f = 0; f < 8; f++) begin e_fail[f] = '0; e_bad[f] = '0; e_hits[f] = 0; end
    for (int p = 0; p < 8; p++) begin
      bit g;
      g = good_tab[ord[p]];
      e_good[7-p] = g;
      e_vhit[p] = 0;
      for (int f = 0; f < 8; f++) begin
        bit b;
        b = bad_tab[f][ord[p]];
        e_bad[f][7-p] = b;
        if (b != g) begin
          e_fail[f][7-p] = 1'b1;
          e_hits[f]++;
          e_vhit[p]++;
          if (!(f inside {seen})) seen.push_back(f);
        end
      end
      e_cum[p] = seen.size();
    end
    e_eq = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (i != j && e_fail[i] == e_fail[j]) e_eq[i*8+j] = 1'b1;
  endtask

  // Cycle-level reference for the handshake
  bit m_busy, m_done;
  int m_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
    end else if (start && !m_busy) begin
      m_busy = 1; m_done = 0; m_cnt = 0;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == 64) begin m_busy = 0; m_done = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n)
      chk(busy == m_busy && done == m_done, "R5/R7 busy-done per cycle",
          {62'd0, busy, done}, {62'd0, m_busy, m_done});
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic run_and_check(input bit disturb);
    vec_order = pack_order();
    build_expect();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    rd_fault = 3'd7; #1;
    chk(rd_fail == 0 && rd_bad == 0 && good_resp == 0 && cum_cov == 0 && vec_hits == 0 && !done,
        "R6 cleared on start", {good_resp, rd_fail, rd_bad}, 64'd0);
    if (disturb) begin
      repeat (10) @(negedge clk);
      start = 1'b1; vec_order = ~vec_order;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    for (int f = 0; f < 8; f++) begin
      rd_fault = 3'(f); #1;
      chk(rd_fail == e_fail[f], "R3 fail pattern", rd_fail, e_fail[f]);
      chk(rd_bad == e_bad[f], "R2 bad response", rd_bad, e_bad[f]);
      chk(rd_hits == 4'(e_hits[f]), "R4 hits per fault", rd_hits, e_hits[f]);
    end
    chk(good_resp == e_good, "R1 good response", good_resp, e_good);
    for (int p = 0; p < 8; p++) begin
      chk(vec_hits[4*p +: 4] == 4'(e_vhit[p]), "R8 faults per vector", vec_hits[4*p +: 4], e_vhit[p]);
      chk(cum_cov[4*p +: 4] == 4'(e_cum[p]), "R9 cumulative coverage", cum_cov[4*p +: 4], e_cum[p]);
    end
    chk(equiv == e_eq, "R10 equivalence matrix", equiv, e_eq);
    repeat (3) @(negedge clk);
    chk(done && !busy, "R5 done held", {busy, done}, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; vec_order = '0; rd_fault = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_fault = 3'd0; #1;
    chk(!busy && !done, "R5 reset idle", {busy, done}, 0);
    chk(rd_fail == 0 && good_resp == 0 && cum_cov == 0 && equiv == 0, "R6 reset empty",
        {rd_fail, good_resp}, 0);

    // Graded order, disturbed mid-run (R7)
    ord = '{3, 4, 2, 7, 0, 1, 5, 6};
    run_and_check(1'b1);
    chk(good_resp == 8'b00110001, "R3 known good response", good_resp, 8'b00110001);
    rd_fault = 3'd0; #1;
    chk(rd_fail == 8'b10000000, "R3 F1 pattern", rd_fail, 8'b10000000);
    rd_fault = 3'd6; #1;
    chk(rd_fail == 8'b11001110, "R3 F7 pattern", rd_fail, 8'b11001110);
    chk(rd_hits == 4'd5, "R4 F7 hit count", rd_hits, 5);
    rd_fault = 3'd7; #1;
    chk(rd_fail == 8'b00110001, "R3 F8 pattern", rd_fail, 8'b00110001);
    chk(cum_cov[15:12] == 4'd8 && cum_cov[11:8] == 4'd7, "R9 full at fourth vector",
        cum_cov[15:8], 8'h87);
    chk(equiv == ((64'd1 << 3) | (64'd1 << 24)), "R10 F1/F4 only", equiv,
        (64'd1 << 3) | (64'd1 << 24));

    ord = '{0, 1, 2, 3, 4, 5, 6, 7};
    run_and_check(1'b0);

    // One vector repeated: no dropping means every position counts (R4)
    ord = '{3, 3, 3, 3, 3, 3, 3, 3};
    run_and_check(1'b0);
    rd_fault = 3'd0; #1;
    chk(rd_hits == 4'd8, "R4 repeated detections", rd_hits, 8);

    ord = '{7, 6, 5, 4, 3, 2, 1, 0};
    run_and_check(1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule